// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Controller

This controller sits beside the decode stage of a five-stage in-order pipeline. For each of the two source register numbers of the instruction in decode, it produces a 2-bit select. The select tells the operand muxes whether to take the register-file value or a result still in flight in the execute, memory or write-back stage. It also produces three control outputs:

- a stall, which freezes the PC and the instruction register;
- a bubble, which clears the control word entering execute;
- a flush, which turns the fetched instruction into a no-op after a jump or a taken branch resolved in decode.

The controller keeps its own record of what each downstream stage will write. Each cycle, the decoded instruction's destination number, write-enable and load flag enter the execute slot of this record and then advance one stage per cycle. A stall places an empty slot in execute instead. After a flush, the instruction that reaches decode next is marked dead, and none of its effects are recorded. The pipeline that uses this controller must hold the decode inputs steady while `stall` is high. The block has no streaming data path, so every pin is a plain control signal with no handshake.

Top module: `hz_unit`

## Requirements
- R1: After reset, no stage holds a pending write. Every source therefore selects the register file (code 0), and `stall` and `flush` are low.
- R2: The select codes are: 0 for the register file, 1 for the result in execute, 2 for the result in memory, and 3 for the result in write-back. An instruction decoded 1, 2 or 3 advancing cycles earlier sits in execute, memory or write-back respectively.
- R3: When several stages match a source, the youngest producer wins, in the order execute, then memory, then write-back.
- R4: A source register number of 0 always gives code 0.
- R5: A stage is a forwarding source only if its write-enable is set and its destination equals the source number.
- R6: `stall` is high exactly when the instruction in execute is a load and at least one select equals 1.
- R7: `bubble` equals `stall`, and a stall is never raised two cycles in a row. If the dependent instruction is held for one cycle, its select then becomes 2.
- R8: `flush` is high in the cycle `id_redirect` is high, provided no stall is raised in that cycle.
- R9: When a stall and a redirect coincide, `stall` wins and `flush` stays low. The redirect is honoured in the cycle after, once the stall has cleared.
- R10: In the cycle after a flush, the instruction in decode is a no-op. Its write, load and redirect inputs are ignored: it never becomes a forwarding source, and it raises no flush.
- R11: A load two instructions ahead of its consumer gives select 2 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_W | First source register number in decode |
| id_rt | input | REG_W | Second source register number in decode |
| id_rd | input | REG_W | Destination register number in decode |
| id_wr | input | 1 | Decoded instruction writes the register file |
| id_load | input | 1 | Decoded instruction is a load |
| id_redirect | input | 1 | Jump or taken branch resolved in decode |
| fwd_a | output | 2 | Select for the first operand |
| fwd_b | output | 2 | Select for the second operand |
| stall | output | 1 | Hold the PC and the instruction register |
| bubble | output | 1 | Clear the control word entering execute |
| flush | output | 1 | Turn the fetched instruction into a no-op |

## Verification
Directed sequences first place a single producer at distances one, two, three and four. This separates the four select codes from one another. Two back-to-back writers to the same register then show that the nearest producer wins. Writes to register 0 and producers with write-enable clear are shown to be inert. Load-use pairs at distance one and distance two separate the stall case from the plain select-2 case. Coinciding stall and redirect show stall precedence and the deferred flush, and the instruction after a flush is shown to leave no trace. A long random stream over four register numbers then exercises the priority chains and stall/flush mixes, checked against the behavioural model every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int HZ_REG_W = 5;
  localparam int HZ_NSTG  = 3;   // execute, memory, write-back

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2,
    SEL_WB  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/hz_track.sv
// Shadow of the downstream stages: destination, write-enable, load flag.
module hz_track #(
  parameter int REG_W = hz_pkg::HZ_REG_W,
  parameter int NSTG  = hz_pkg::HZ_NSTG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insert_bubble,
  input  logic [REG_W-1:0] dec_rd,
  input  logic             dec_wr,
  input  logic             dec_load,
  output logic [REG_W-1:0] stg_rd [NSTG],
  output logic             stg_wr [NSTG],
  output logic             ex_load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTG; i++) begin
        stg_rd[i] <= '0;
        stg_wr[i] <= 1'b0;
      end
      ex_load <= 1'b0;
    end else begin
      for (int i = 1; i < NSTG; i++) begin
        stg_rd[i] <= stg_rd[i-1];
        stg_wr[i] <= stg_wr[i-1];
      end
      stg_rd[0] <= insert_bubble ? '0   : dec_rd;
      stg_wr[0] <= insert_bubble ? 1'b0 : dec_wr;
      ex_load   <= insert_bubble ? 1'b0 : dec_load;
    end
  end
endmodule

// File: rtl/hz_fwd_sel.sv
// Priority select for one source operand; youngest producer first.
module hz_fwd_sel #(
  parameter int REG_W = hz_pkg::HZ_REG_W,
  parameter int NSTG  = hz_pkg::HZ_NSTG
) (
  input  logic             [REG_W-1:0] src,
  input  logic             [REG_W-1:0] stg_rd [NSTG],
  input  logic                         stg_wr [NSTG],
  output hz_pkg::fwd_sel_e             sel
);
  always_comb begin
    sel = hz_pkg::SEL_RF;
    if (src != '0) begin
      for (int i = NSTG - 1; i >= 0; i--) begin
        if (stg_wr[i] && stg_rd[i] == src) sel = hz_pkg::fwd_sel_e'(i + 1);
      end
    end
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int REG_W = hz_pkg::HZ_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_wr,
  input  logic             id_load,
  input  logic             id_redirect,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble,
  output logic             flush
);
  import hz_pkg::*;
  localparam int NSTG = HZ_NSTG;
  localparam int NSRC = 2;

  logic             killed_q;
  logic             dec_live;
  logic [REG_W-1:0] stg_rd [NSTG];
  logic             stg_wr [NSTG];
  logic             ex_load;
  logic [REG_W-1:0] srcs   [NSRC];
  fwd_sel_e         sels   [NSRC];
  logic             use_ex;

  assign dec_live = !killed_q;
  assign srcs[0]  = id_rs;
  assign srcs[1]  = id_rt;

  hz_track #(.REG_W(REG_W), .NSTG(NSTG)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .insert_bubble (stall),
    .dec_rd        (id_rd),
    .dec_wr        (id_wr & dec_live),
    .dec_load      (id_load & id_wr & dec_live),
    .stg_rd        (stg_rd),
    .stg_wr        (stg_wr),
    .ex_load       (ex_load)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_fwd_sel #(.REG_W(REG_W), .NSTG(NSTG)) u_sel (
      .src    (srcs[g]),
      .stg_rd (stg_rd),
      .stg_wr (stg_wr),
      .sel    (sels[g])
    );
  end

  assign fwd_a  = sels[0];
  assign fwd_b  = sels[1];
  assign use_ex = (sels[0] == SEL_EX) || (sels[1] == SEL_EX);
  assign stall  = dec_live && ex_load && use_ex;
  assign bubble = stall;
  assign flush  = dec_live && id_redirect && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) killed_q <= 1'b0;
    else        killed_q <= flush;
  end
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int REG_W = hz_pkg::HZ_REG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] id_rt,
  input logic             id_redirect,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             stall,
  input logic             bubble,
  input logic             flush
);
  AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0) |-> (fwd_a == 2'd0)); // R4
  AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rt == '0) |-> (fwd_b == 2'd0)); // R4
  AST_STALL_NEEDS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (fwd_a == 2'd1 || fwd_b == 2'd1)); // R6
  AST_NO_DOUBLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R7
  AST_BUBBLE_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bubble == stall); // R7
  AST_STALL_BEATS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && flush)); // R9
  AST_FLUSH_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> id_redirect); // R8
  AST_NO_BACK_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R10
endmodule

bind hz_unit hz_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_hz_unit.sv
`timescale 1ns/1ps
module sim_hz_unit;
  localparam int REG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [REG_W-1:0] id_rs = '0, id_rt = '0, id_rd = '0;
  logic             id_wr = 1'b0, id_load = 1'b0, id_redirect = 1'b0;
  logic [1:0]       fwd_a, fwd_b;
  logic             stall, bubble, flush;

  int checks = 0;
  int errors = 0;

  // reference state: index 0 execute, 1 memory, 2 write-back
  int  m_rd [3];
  bit  m_wr [3];
  bit  m_ld;
  bit  m_killed;
  bit  last_stall;

  always #2 clk = ~clk;

  hz_unit #(.REG_W(REG_W)) u0 (.*);

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int ref_sel(int src);
    if (src == 0) return 0;
    for (int i = 0; i < 3; i++)
      if (m_wr[i] && m_rd[i] == src) return i + 1;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_rd[i] = 0; m_wr[i] = 0; end
    m_ld = 0; m_killed = 0; last_stall = 0;
  endtask

  // drive one decode slot, compare, then advance the model at the edge
  task automatic step(int rs, int rt, int rd, bit wr, bit ld, bit redir, string tag);
    int ea, eb;
    bit es, ef;
    id_rs = rs[REG_W-1:0]; id_rt = rt[REG_W-1:0]; id_rd = rd[REG_W-1:0];
    id_wr = wr; id_load = ld; id_redirect = redir;
    #1;
    ea = ref_sel(rs);
    eb = ref_sel(rt);
    es = !m_killed && m_ld && (ea == 1 || eb == 1);
    ef = !m_killed && redir && !es;
    checks++;
    if (fwd_a != ea[1:0] || fwd_b != eb[1:0] || stall != es || bubble != es || flush != ef) begin
      errors++;
      $display("FAIL %s: actual a=%0d b=%0d st=%0d bu=%0d fl=%0d expected a=%0d b=%0d st=%0d bu=%0d fl=%0d",
               tag, fwd_a, fwd_b, stall, bubble, flush, ea, eb, es, es, ef);
    end
    @(posedge clk);
    m_rd[2] = m_rd[1]; m_wr[2] = m_wr[1];
    m_rd[1] = m_rd[0]; m_wr[1] = m_wr[0];
    if (es) begin
      m_rd[0] = 0; m_wr[0] = 0; m_ld = 0;
    end else begin
      m_rd[0] = rd; m_wr[0] = wr && !m_killed; m_ld = ld && wr && !m_killed;
    end
    m_killed = ef;
    last_stall = es;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    step(5, 6, 0, 0, 0, 0, "R1");
    // R2: single producer at distance 1..4
    step(0, 0, 5, 1, 0, 0, "R2");
    step(5, 0, 0, 0, 0, 0, "R2");
    step(0, 5, 0, 0, 0, 0, "R2");
    step(5, 5, 0, 0, 0, 0, "R2");
    step(5, 0, 0, 0, 0, 0, "R2");
    // R3: two writers of r6, youngest wins
    step(0, 0, 6, 1, 0, 0, "R3");
    step(0, 0, 6, 1, 0, 0, "R3");
    step(6, 6, 0, 0, 0, 0, "R3");
    idle(3);
    // R4: writes to r0 never forward
    step(0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    // R5: write-enable clear means no forward
    step(0, 0, 7, 0, 0, 0, "R5");
    step(7, 7, 0, 0, 0, 0, "R5");
    idle(3);
    // R6/R7: load-use at distance 1, held one cycle
    step(0, 0, 8, 1, 1, 0, "R6");
    step(1, 8, 9, 1, 0, 0, "R6");
    step(1, 8, 9, 1, 0, 0, "R7");
    idle(3);
    // R11: load two ahead gives select 2, no stall
    step(0, 0, 8, 1, 1, 0, "R11");
    step(0, 0, 0, 0, 0, 0, "R11");
    step(8, 0, 0, 0, 0, 0, "R11");
    idle(3);
    // R8: plain redirect
    step(0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, "R10");
    idle(2);
    // R9: stall and redirect together, flush deferred
    step(0, 0, 9, 1, 1, 0, "R9");
    step(9, 0, 0, 0, 0, 1, "R9");
    step(9, 0, 0, 0, 0, 1, "R9");
    // R10: killed slot writes r10 and redirects: ignored
    step(0, 0, 10, 1, 1, 1, "R10");
    step(10, 10, 0, 0, 0, 0, "R10");
    step(0, 10, 0, 0, 0, 0, "R10");
    idle(3);
    // random stream, R3 priority under mixed traffic
    begin
      int rs, rt, rd;
      bit wr, ld, rdr;
      rs = 0; rt = 0; rd = 0; wr = 0; ld = 0; rdr = 0;
      for (int i = 0; i < 2000; i++) begin
        if (!last_stall) begin
          rs = $urandom_range(0, 3); rt = $urandom_range(0, 3);
          rd = $urandom_range(0, 3); wr = $urandom_range(0, 1);
          ld = ($urandom_range(0, 2) == 0); rdr = ($urandom_range(0, 6) == 0);
        end
        step(rs, rt, rd, wr, ld, rdr, "R3");
      end
    end
    // reset in flight returns to empty state
    id_rs = 1; rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    step(1, 2, 0, 0, 0, 0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule